// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block moves a core clock between five divide ratios, /1, /2, /4, /6 and /8. A caller hands it a target ratio index over a valid/ready request port. The block then writes a 3-bit divider-select register and a memory-controller control word in a fixed order, with waits between the writes. The control word holds a self-refresh enable and a 7-bit refresh count. The phase-locked loop and the DRAM controller are outside the block. The block sees them only as the registers it writes and the time it waits on them.

A change of ratio is a short program, not a single write. A jump between /1 and any of /4, /6 or /8 always stops at /2 first, in both directions. Going faster, the divider is written before the refresh count. Going slower, the refresh count is written first. Self-refresh is enabled only while the clock runs at /2 or slower. After every divider write the block holds off for the PLL to lock. When a step slows the clock while self-refresh is off, the block also waits for the old and new refresh counts to drain. The refresh count for each ratio is fixed at build time from the base clock frequency parameter.

Top module: `clkdiv_seq`

## Requirements
- R1: After reset the divider select is 000 (/1), self-refresh enable is 0, the refresh count holds the /1 value, `busy` is 0 and `req_ready` is 1.
- R2: Ratio indices 0..4 mean /1, /2, /4, /6, /8. Their divider-select codes are 000, 001, 011, 010, 100, and `div_sel` never holds any other code.
- R3: A change between /1 and /4, /6 or /8 runs as two steps through /2 (code 001) in both directions. The divider never goes straight from 000 to anything but 001, and never reaches 000 from anything but 001.
- R4: A /2 to /1 step writes the control word with self-refresh cleared, then the divider code 000, then the /1 refresh count.
- R5: A /1 to /2 step writes the /2 refresh count first. It then waits at least 64 × (old count + new count) × old divisor cycles, writes divider code 001, and finally writes the control word with self-refresh set.
- R6: Between two ratios that are both /2 or slower, a slowing step writes the refresh count and then the divider. A speeding step writes the divider and then the refresh count. Neither step waits for a drain, because self-refresh is on.
- R7: After every divider write, at least 16 cycles pass before the next write to either register.
- R8: The control word is 17 bits. Self-refresh enable is at bit 16, the refresh count at bits 14:8, and all other bits are 0. The count for divisor d is floor(BASE_MHZ × 7800 / (1000 × 64 × d)), which gives 48, 24, 12, 8 and 6 at 400 MHz.
- R9: A request whose target equals the current ratio is accepted and causes no register write, and `busy` stays low.
- R10: A request with an index above 4 is accepted. It raises `req_err` for exactly one cycle, one cycle after the handshake, and causes no register write.
- R11: `busy` is high from the cycle after acceptance until the last wait has ended. `req_ready` is low while `busy` is high, so no request is taken then.
- R12: Self-refresh enable is 1 only while the divider select is not 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the base clock the wait periods count |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_idx | input | 3 | Target ratio index (0..4) |
| req_ready | output | 1 | High while the block can take a request |
| req_err | output | 1 | One-cycle pulse for a rejected index |
| busy | output | 1 | Transition in progress |
| div_sel | output | 3 | Divider-select register |
| div_we | output | 1 | One-cycle strobe when `div_sel` is written |
| memctl | output | 17 | Memory-controller control word |
| memctl_we | output | 1 | One-cycle strobe when `memctl` is written |

## Verification
The transition table runs a chain of requests that covers every kind of step. The kinds are a one-step slowing from /1 with a drain wait, slowing and speeding steps among the slow ratios, both two-step detours through /2 (from /1 and back to /1), and moves that end on /6 and /4. The bench records the order of the write strobes and the divider codes written. From these it can tell a wrong step order, a missing detour, a mis-encoded ratio and a skipped drain or lock wait apart. Directed cases cover the reset word, a same-ratio request, out-of-range indices, and requests held during a busy transition.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int NUM_RATIOS = 5;
    localparam int IDX_W      = 3;
    localparam int CODE_W     = 3;
    localparam int CNT_W      = 7;
    localparam int MAX_IDX    = NUM_RATIOS - 1;

    typedef logic [CODE_W-1:0] div_code_t;
    typedef logic [IDX_W-1:0]  ratio_idx_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SR_CLR,
        OP_SR_SET,
        OP_REFRESH,
        OP_DIVIDER
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PLAN,
        ST_EXEC,
        ST_WAIT
    } state_e;

    // Memory-controller control word: enable at bit 16, count at 14:8.
    typedef struct packed {
        logic             self_refresh;
        logic             rsvd_hi;
        logic [CNT_W-1:0] refr_cnt;
        logic [7:0]       rsvd_lo;
    } memctl_t;

    typedef struct packed {
        ratio_idx_t   to_idx;
        logic         slowing;
        op_e [3:0]    ops;
    } step_plan_t;

    function automatic div_code_t idx_to_code(ratio_idx_t idx);
        case (idx)
            3'd0:    return 3'b000;
            3'd1:    return 3'b001;
            3'd2:    return 3'b011;
            3'd3:    return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic ratio_idx_t code_to_idx(div_code_t code);
        case (code)
            3'b000:  return 3'd0;
            3'b001:  return 3'd1;
            3'b011:  return 3'd2;
            3'b010:  return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [3:0] idx_to_div(ratio_idx_t idx);
        case (idx)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_refresh_table.sv
module clkdiv_refresh_table
    import clkdiv_pkg::*;
#(
    parameter int unsigned BASE_MHZ      = 400,
    parameter int unsigned REFRESH_NS    = 7800,
    parameter int unsigned CLKS_PER_UNIT = 64
) (
    output logic [NUM_RATIOS-1:0][CNT_W-1:0] cnt_tbl
);

    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_ratio
        localparam int unsigned DIVV = (i == 0) ? 1 : (i == 1) ? 2 :
                                       (i == 2) ? 4 : (i == 3) ? 6 : 8;
        localparam int unsigned RAW  = (BASE_MHZ * REFRESH_NS) /
                                       (1000 * CLKS_PER_UNIT * DIVV);
        localparam int unsigned SAT  = (RAW > CNT_MAX) ? CNT_MAX : RAW;
        assign cnt_tbl[i] = CNT_W'(SAT);
    end

endmodule

// File: rtl/clkdiv_step_plan.sv
module clkdiv_step_plan
    import clkdiv_pkg::*;
(
    input  ratio_idx_t cur_idx,
    input  ratio_idx_t tgt_idx,
    output step_plan_t plan
);

    logic       far_jump;
    ratio_idx_t step_to;

    always_comb begin
        far_jump = ((cur_idx == 3'd0) && (tgt_idx > 3'd1)) ||
                   ((cur_idx > 3'd1) && (tgt_idx == 3'd0));
        step_to  = far_jump ? 3'd1 : tgt_idx;

        plan.to_idx  = step_to;
        plan.slowing = (step_to > cur_idx);
        plan.ops     = {OP_NONE, OP_NONE, OP_NONE, OP_NONE};

        if ((cur_idx == 3'd1) && (step_to == 3'd0)) begin
            plan.ops[0] = OP_SR_CLR;
            plan.ops[1] = OP_DIVIDER;
            plan.ops[2] = OP_REFRESH;
        end else if ((cur_idx == 3'd0) && (step_to == 3'd1)) begin
            plan.ops[0] = OP_REFRESH;
            plan.ops[1] = OP_DIVIDER;
            plan.ops[2] = OP_SR_SET;
        end else if (step_to > cur_idx) begin
            plan.ops[0] = OP_REFRESH;
            plan.ops[1] = OP_DIVIDER;
        end else begin
            plan.ops[0] = OP_DIVIDER;
            plan.ops[1] = OP_REFRESH;
        end
    end

endmodule

// File: rtl/clkdiv_drain_calc.sv
module clkdiv_drain_calc
    import clkdiv_pkg::*;
#(
    parameter int unsigned CLKS_PER_UNIT = 64,
    parameter int          WAIT_W        = 17
) (
    input  logic [CNT_W-1:0]  old_cnt,
    input  logic [CNT_W-1:0]  new_cnt,
    input  ratio_idx_t        old_idx,
    output logic [WAIT_W-1:0] cycles
);

    logic [WAIT_W-1:0] cnt_sum;
    logic [WAIT_W-1:0] old_div;

    assign cnt_sum = WAIT_W'(old_cnt) + WAIT_W'(new_cnt);
    assign old_div = WAIT_W'(idx_to_div(old_idx));
    assign cycles  = WAIT_W'(CLKS_PER_UNIT) * cnt_sum * old_div;

endmodule

// File: rtl/clkdiv_wait_timer.sv
module clkdiv_wait_timer #(
    parameter int WAIT_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              last
);

    logic [WAIT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain <= WAIT_W'(1));

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int unsigned BASE_MHZ      = 400,
    parameter int unsigned REFRESH_NS    = 7800,
    parameter int unsigned CLKS_PER_UNIT = 64,
    parameter int unsigned LOCK_CYCLES   = 16,
    parameter int          WAIT_W        = 17
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_idx,
    output logic        req_ready,
    output logic        req_err,
    output logic        busy,
    output logic [2:0]  div_sel,
    output logic        div_we,
    output logic [16:0] memctl,
    output logic        memctl_we
);

    state_e      state_q;
    div_code_t   div_q;
    memctl_t     memctl_q;
    logic        div_we_q;
    logic        memctl_we_q;
    logic        err_q;
    ratio_idx_t  tgt_q;
    ratio_idx_t  from_q;
    step_plan_t  plan_q;
    step_plan_t  plan_d;
    logic [1:0]  ptr_q;

    logic [NUM_RATIOS-1:0][CNT_W-1:0] cnt_tbl;
    logic [WAIT_W-1:0] drain_cycles;
    logic [WAIT_W-1:0] wait_val;
    logic              wait_load;
    logic              wait_last;
    ratio_idx_t        cur_idx;
    op_e               cur_op;
    logic              need_drain;

    assign cur_idx = code_to_idx(div_q);
    assign cur_op  = plan_q.ops[ptr_q];

    clkdiv_refresh_table #(
        .BASE_MHZ      (BASE_MHZ),
        .REFRESH_NS    (REFRESH_NS),
        .CLKS_PER_UNIT (CLKS_PER_UNIT)
    ) u_table (
        .cnt_tbl (cnt_tbl)
    );

    clkdiv_step_plan u_plan (
        .cur_idx (cur_idx),
        .tgt_idx (tgt_q),
        .plan    (plan_d)
    );

    clkdiv_drain_calc #(
        .CLKS_PER_UNIT (CLKS_PER_UNIT),
        .WAIT_W        (WAIT_W)
    ) u_drain (
        .old_cnt (memctl_q.refr_cnt),
        .new_cnt (cnt_tbl[plan_q.to_idx]),
        .old_idx (from_q),
        .cycles  (drain_cycles)
    );

    // A slowing refresh write with self-refresh off must let both counts drain.
    assign need_drain = plan_q.slowing && !memctl_q.self_refresh;

    always_comb begin
        wait_load = 1'b0;
        wait_val  = WAIT_W'(LOCK_CYCLES);
        if (state_q == ST_EXEC) begin
            if (cur_op == OP_DIVIDER) begin
                wait_load = 1'b1;
            end else if ((cur_op == OP_REFRESH) && need_drain) begin
                wait_load = 1'b1;
                wait_val  = drain_cycles;
            end
        end
    end

    clkdiv_wait_timer #(
        .WAIT_W (WAIT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_val),
        .last     (wait_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q              <= ST_IDLE;
            div_q                <= idx_to_code(3'd0);
            memctl_q             <= '0;
            memctl_q.refr_cnt    <= cnt_tbl[0];
            div_we_q             <= 1'b0;
            memctl_we_q          <= 1'b0;
            err_q                <= 1'b0;
            tgt_q                <= '0;
            from_q               <= '0;
            plan_q               <= '0;
            ptr_q                <= '0;
        end else begin
            div_we_q    <= 1'b0;
            memctl_we_q <= 1'b0;
            err_q       <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_idx > 3'(MAX_IDX)) begin
                            err_q <= 1'b1;
                        end else if (req_idx != cur_idx) begin
                            tgt_q   <= req_idx;
                            state_q <= ST_PLAN;
                        end
                    end
                end
                ST_PLAN: begin
                    plan_q  <= plan_d;
                    from_q  <= cur_idx;
                    ptr_q   <= '0;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    case (cur_op)
                        OP_SR_CLR: begin
                            memctl_q.self_refresh <= 1'b0;
                            memctl_we_q           <= 1'b1;
                            ptr_q                 <= ptr_q + 2'd1;
                        end
                        OP_SR_SET: begin
                            memctl_q.self_refresh <= 1'b1;
                            memctl_we_q           <= 1'b1;
                            ptr_q                 <= ptr_q + 2'd1;
                        end
                        OP_REFRESH: begin
                            memctl_q.refr_cnt <= cnt_tbl[plan_q.to_idx];
                            memctl_we_q       <= 1'b1;
                            ptr_q             <= ptr_q + 2'd1;
                            if (need_drain) begin
                                state_q <= ST_WAIT;
                            end
                        end
                        OP_DIVIDER: begin
                            div_q    <= idx_to_code(plan_q.to_idx);
                            div_we_q <= 1'b1;
                            ptr_q    <= ptr_q + 2'd1;
                            state_q  <= ST_WAIT;
                        end
                        default: begin
                            state_q <= (plan_q.to_idx == tgt_q) ? ST_IDLE : ST_PLAN;
                        end
                    endcase
                end
                ST_WAIT: begin
                    if (wait_last) begin
                        state_q <= ST_EXEC;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign req_err   = err_q;
    assign div_sel   = div_q;
    assign div_we    = div_we_q;
    assign memctl    = memctl_q;
    assign memctl_we = memctl_we_q;

endmodule

// File: rtl/clkdiv_seq_chk.sv
module clkdiv_seq_chk #(
    parameter int unsigned LOCK_CYCLES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_idx,
    input logic        req_ready,
    input logic        req_err,
    input logic        busy,
    input logic [2:0]  div_sel,
    input logic        div_we,
    input logic [16:0] memctl,
    input logic        memctl_we
);

    localparam int SW = $clog2(LOCK_CYCLES + 1) + 1;

    logic [SW-1:0] since_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_div <= SW'(LOCK_CYCLES);
        end else if (div_we) begin
            since_div <= '0;
        end else if (since_div < SW'(LOCK_CYCLES)) begin
            since_div <= since_div + 1'b1;
        end
    end

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
        div_sel inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100});

    assert_detour_up_R3: assert property (@(posedge clk) disable iff (rst)
        (div_we && ($past(div_sel) == 3'b000)) |-> (div_sel == 3'b001));

    assert_detour_down_R3: assert property (@(posedge clk) disable iff (rst)
        (div_we && (div_sel == 3'b000)) |-> ($past(div_sel) == 3'b001));

    assert_lock_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (div_we || memctl_we) |-> (since_div >= SW'(LOCK_CYCLES)));

    assert_field_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (memctl[15] == 1'b0) && (memctl[7:0] == 8'd0));

    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!div_we && !memctl_we));

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        req_err |=> !req_err);

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
        req_err |-> $past(req_valid && req_ready && (req_idx > 3'd4)));

    assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    assert_sr_slow_only_R12: assert property (@(posedge clk) disable iff (rst)
        memctl[16] |-> (div_sel != 3'b000));

endmodule

bind clkdiv_seq clkdiv_seq_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .req_ready (req_ready),
    .req_err   (req_err),
    .busy      (busy),
    .div_sel   (div_sel),
    .div_we    (div_we),
    .memctl    (memctl),
    .memctl_we (memctl_we)
);

// File: tb/clkdiv_seq_bench.sv
`timescale 1ns/1ps
module clkdiv_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_idx = 3'd0;
    logic        req_ready;
    logic        req_err;
    logic        busy;
    logic [2:0]  div_sel;
    logic        div_we;
    logic [16:0] memctl;
    logic        memctl_we;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic       ev_div  [8];
    logic [2:0] ev_code [8];
    int         ev_t    [8];
    int         nev = 0;

    clkdiv_seq u_clkdiv_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_idx   (req_idx),
        .req_ready (req_ready),
        .req_err   (req_err),
        .busy      (busy),
        .div_sel   (div_sel),
        .div_we    (div_we),
        .memctl    (memctl),
        .memctl_we (memctl_we)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc++;

    // Record every register write at the negative edge.
    always @(negedge clk) begin
        if (!rst && nev < 8) begin
            if (div_we) begin
                ev_div[nev]  = 1'b1;
                ev_code[nev] = div_sel;
                ev_t[nev]    = cyc;
                nev++;
            end else if (memctl_we) begin
                ev_div[nev]  = 1'b0;
                ev_code[nev] = 3'd0;
                ev_t[nev]    = cyc;
                nev++;
            end
        end
    end

    // {tgt, nev, order (bit k = 1 when write k is the divider), div0, div1, cnt, sr, min gap}
    localparam logic [41:0] VEC [11] = '{
        {3'd1, 3'd3, 6'b000010, 3'b001, 3'b000, 7'd24, 1'b1, 16'd4608},
        {3'd2, 3'd2, 6'b000010, 3'b011, 3'b000, 7'd12, 1'b1, 16'd1},
        {3'd4, 3'd2, 6'b000010, 3'b100, 3'b000, 7'd6,  1'b1, 16'd1},
        {3'd3, 3'd2, 6'b000001, 3'b010, 3'b000, 7'd8,  1'b1, 16'd16},
        {3'd0, 3'd5, 6'b001001, 3'b001, 3'b000, 7'd48, 1'b0, 16'd16},
        {3'd4, 3'd5, 6'b010010, 3'b001, 3'b100, 7'd6,  1'b1, 16'd4608},
        {3'd1, 3'd2, 6'b000001, 3'b001, 3'b000, 7'd24, 1'b1, 16'd16},
        {3'd0, 3'd3, 6'b000010, 3'b000, 3'b000, 7'd48, 1'b0, 16'd1},
        {3'd3, 3'd5, 6'b010010, 3'b001, 3'b010, 7'd8,  1'b1, 16'd4608},
        {3'd2, 3'd2, 6'b000001, 3'b011, 3'b000, 7'd12, 1'b1, 16'd16},
        {3'd0, 3'd5, 6'b001001, 3'b001, 3'b000, 7'd48, 1'b0, 16'd16}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic send_req(input logic [2:0] idx);
        @(negedge clk);
        req_valid = 1'b1;
        req_idx   = idx;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 30000 && busy; t++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R11", "watchdog expired busy", int'(busy), 0);
        finish_run();
    end

    initial begin
        int div_k;
        logic [5:0] sig;
        logic [41:0] v;
        bit saw_ready;
        bit saw_busy;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check(div_sel == 3'b000, "R1", "reset div_sel", div_sel, 0);
        check(memctl == {1'b0, 1'b0, 7'd48, 8'd0}, "R1", "reset memctl", memctl, 48 << 8);
        check(!busy && req_ready && !req_err, "R1", "reset busy/ready/err",
              {busy, req_ready, req_err}, 3'b010);

        // Transition table
        for (int i = 0; i < 11; i++) begin
            v = VEC[i];
            nev = 0;
            send_req(v[41:39]);
            check(!busy, "R11", $sformatf("vec %0d busy ended", i), busy, 0);
            check(nev == int'(v[38:36]), "R3", $sformatf("vec %0d write count", i),
                  nev, v[38:36]);
            sig = '0;
            for (int k = 0; k < 6; k++) if (k < nev) sig[k] = ev_div[k];
            check(sig == v[35:30], "R4 R5 R6", $sformatf("vec %0d write order", i),
                  sig, v[35:30]);
            div_k = 0;
            for (int k = 0; k < nev; k++) begin
                if (ev_div[k]) begin
                    check(ev_code[k] == ((div_k == 0) ? v[29:27] : v[26:24]), "R2",
                          $sformatf("vec %0d divider code %0d", i, div_k),
                          ev_code[k], (div_k == 0) ? v[29:27] : v[26:24]);
                    div_k++;
                    if (k + 1 < nev)
                        check(ev_t[k+1] - ev_t[k] >= 16, "R7",
                              $sformatf("vec %0d lock gap", i), ev_t[k+1] - ev_t[k], 16);
                end
            end
            if (nev >= 2)
                check(ev_t[1] - ev_t[0] >= int'(v[15:0]), "R5",
                      $sformatf("vec %0d first gap", i), ev_t[1] - ev_t[0], v[15:0]);
            check(memctl[14:8] == v[23:17], "R8", $sformatf("vec %0d refresh count", i),
                  memctl[14:8], v[23:17]);
            check(memctl[16] == v[16], "R12", $sformatf("vec %0d self-refresh", i),
                  memctl[16], v[16]);
            check(memctl[15] == 1'b0 && memctl[7:0] == 8'd0, "R8",
                  $sformatf("vec %0d reserved bits", i), {memctl[15], memctl[7:0]}, 0);
        end

        // Same target (currently /1)
        nev = 0;
        saw_busy = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_idx   = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 30; t++) begin
            if (busy) saw_busy = 1'b1;
            @(negedge clk);
        end
        check(nev == 0, "R9", "same-target writes", nev, 0);
        check(!saw_busy, "R9", "same-target busy", saw_busy, 0);

        // Out-of-range indices
        for (int e = 5; e < 8; e += 2) begin
            nev = 0;
            @(negedge clk);
            req_valid = 1'b1;
            req_idx   = 3'(e);
            @(negedge clk);
            req_valid = 1'b0;
            check(req_err == 1'b1, "R10", $sformatf("error pulse idx %0d", e), req_err, 1);
            @(negedge clk);
            check(req_err == 1'b0, "R10", $sformatf("error width idx %0d", e), req_err, 0);
            repeat (30) @(negedge clk);
            check(nev == 0 && div_sel == 3'b000, "R10",
                  $sformatf("no writes idx %0d", e), nev, 0);
        end

        // Request held while busy is not taken
        nev = 0;
        saw_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_idx   = 3'd1;
        @(negedge clk);
        req_idx   = 3'd4;
        for (int t = 0; t < 30000; t++) begin
            if (!busy) begin
                req_valid = 1'b0;
                break;
            end
            if (req_ready) saw_ready = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        check(!saw_ready, "R11", "ready during busy", saw_ready, 0);
        check(div_sel == 3'b001, "R11", "held request ignored div_sel", div_sel, 3'b001);
        check(!busy, "R11", "no second transition", busy, 0);

        finish_run();
    end

endmodule